// File: doc/BRIEF.md
# Accumulator Compare Branch Unit

This block settles conditional jumps on a machine built around a single accumulator. A branch instruction supplies a 16-bit jump target, and after it a compare operand. The operand is either a 16-bit literal or a register index. The decoder has already fetched both fields. It presents them together with the decoded condition, the live register bank, the accumulator and the fall-through address, which is the address just past the instruction. The unit returns a taken flag and the next instruction pointer. The fetch stage loads that pointer.

Each condition is evaluated with the operand on the left-hand side: "greater" means the operand exceeds the accumulator. Values are treated as two's-complement 16-bit numbers. The whole path is combinational, so its results belong to the same cycle in which the decoder marks the operand valid.

Top module: `acc_branch_unit`

## Requirements
- R1: While `op_valid` is low, `taken` is 0 and `ip_out` equals `fall_ip`, whatever the other inputs are.
- R2: Condition code 0 (unconditional) is taken whenever `op_valid` is high.
- R3: Condition code 1 (not-equal) is taken when operand != accumulator.
- R4: Condition code 2 (equal) is taken when operand == accumulator.
- R5: Condition code 3 (greater) is taken when operand > accumulator, compared as signed 16-bit values.
- R6: Condition code 4 (less) is taken when operand < accumulator, compared as signed 16-bit values.
- R7: Condition code 5 (greater-or-equal) is taken when operand >= accumulator, compared as signed.
- R8: Condition code 6 (less-or-equal) is taken when operand <= accumulator, compared as signed.
- R9: Condition code 7 is reserved and is never taken.
- R10: With `use_imm` high the operand is `imm_val`. With `use_imm` low it is register `reg_idx` of `reg_bank`, where register i occupies bits [16*i+15 : 16*i].
- R11: A register index of `NREGS` (16) or above reads as zero.
- R12: `ip_out` equals `jump_target` when taken and `fall_ip` otherwise.
- R13: `taken` and `ip_out` follow input changes within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_valid | input | 1 | Decoder has a branch with all fields ready |
| cond_code | input | 3 | Decoded condition, encoding as in R2 to R9 |
| use_imm | input | 1 | 1: operand is the literal, 0: operand comes from a register |
| imm_val | input | 16 | Literal compare operand |
| reg_idx | input | 8 | Register index of the compare operand |
| reg_bank | input | 256 | Flattened register bank, 16 registers of 16 bits |
| acc_val | input | 16 | Current accumulator value |
| jump_target | input | 16 | Branch destination from the instruction |
| fall_ip | input | 16 | Address just past the instruction |
| taken | output | 1 | Branch condition holds |
| ip_out | output | 16 | Next instruction pointer |

## Verification
The bench targets the signed boundaries, for example 0x8000 against 0x7FFF and -1 against 0. An unsigned comparator reverses the outcome of every ordered condition there. Exact equality is the case that separates greater from greater-or-equal and less from less-or-equal. A design that compared accumulator against operand would take a branch on "greater" where it must fall through. The bench also covers register indices at the last implemented slot and well past it. A decoder that wraps or aliases the index returns a live register instead of zero. Idle cycles and the reserved code must fall through even when the compare result would otherwise take the branch.

// File: rtl/abu_pkg.sv
// Package: shared condition encoding for the accumulator branch unit.
// Assumes a 3-bit condition field supplied by the instruction decoder.
package abu_pkg;
    localparam int COND_W = 3;

    typedef enum logic [COND_W-1:0] {
        BR_ALWAYS = 3'd0,
        BR_NE     = 3'd1,
        BR_EQ     = 3'd2,
        BR_GT     = 3'd3,
        BR_LT     = 3'd4,
        BR_GE     = 3'd5,
        BR_LE     = 3'd6,
        BR_NEVER  = 3'd7
    } br_cond_e;
endpackage

// File: rtl/abu_operand_sel.sv
// Module: picks the compare operand, either the literal or one register of
// the flattened bank. Indices at or past NREGS return zero.
// Assumes register i sits at bits [DW*i +: DW] of reg_bank.
module abu_operand_sel #(
    parameter int DW    = 16,
    parameter int NREGS = 16,
    parameter int IDX_W = 8
) (
    input  logic                  use_imm,
    input  logic [DW-1:0]         imm_val,
    input  logic [IDX_W-1:0]      reg_idx,
    input  logic [NREGS*DW-1:0]   reg_bank,
    output logic [DW-1:0]         operand
);
    logic [NREGS-1:0]  hit;
    logic [DW-1:0]     pick [NREGS];
    logic [DW-1:0]     reg_val;

    // one comparator per implemented register; unmatched slots give zero
    for (genvar g = 0; g < NREGS; g++) begin : g_slot
        assign hit[g]  = (reg_idx == IDX_W'(g));
        assign pick[g] = hit[g] ? reg_bank[g*DW +: DW] : '0;
    end

    // OR-merge of the one-hot picks; no hit means zero
    always_comb begin
        reg_val = '0;
        for (int i = 0; i < NREGS; i++) begin
            reg_val = reg_val | pick[i];
        end
    end

    // choose literal or register contents
    always_comb begin
        operand = use_imm ? imm_val : reg_val;
    end
endmodule

// File: rtl/abu_cond_eval.sv
// Module: evaluates the branch condition with the operand on the left of
// each relation and the accumulator on the right, using signed arithmetic.
// Assumes the condition is meaningful only while op_valid is high.
module abu_cond_eval
    import abu_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic              op_valid,
    input  logic [COND_W-1:0] cond_code,
    input  logic [DW-1:0]     operand,
    input  logic [DW-1:0]     acc_val,
    output logic              taken
);
    logic signed [DW-1:0] s_op;
    logic signed [DW-1:0] s_acc;
    logic                 is_eq;
    logic                 is_gt;
    logic                 hold;

    assign s_op  = operand;
    assign s_acc = acc_val;

    // shared relations feed every condition
    always_comb begin
        is_eq = (s_op == s_acc);
        is_gt = (s_op >  s_acc);
    end

    // map the decoded condition to a raw decision
    always_comb begin
        unique case (br_cond_e'(cond_code))
            BR_ALWAYS: hold = 1'b1;
            BR_NE:     hold = !is_eq;
            BR_EQ:     hold = is_eq;
            BR_GT:     hold = is_gt;
            BR_LT:     hold = !is_gt && !is_eq;
            BR_GE:     hold = is_gt || is_eq;
            BR_LE:     hold = !is_gt;
            default:   hold = 1'b0;
        endcase
    end

    // qualify by the decoder's valid strobe
    always_comb begin
        taken = op_valid && hold;
    end
endmodule

// File: rtl/acc_branch_unit.sv
// Module: top of the accumulator compare branch unit. Selects the operand,
// evaluates the condition and chooses the next instruction pointer.
// Assumes the decoder supplies the target and fall-through addresses.
module acc_branch_unit
    import abu_pkg::*;
#(
    parameter int DW    = 16,
    parameter int NREGS = 16,
    parameter int IDX_W = 8,
    parameter int AW    = 16
) (
    input  logic                 op_valid,
    input  logic [COND_W-1:0]    cond_code,
    input  logic                 use_imm,
    input  logic [DW-1:0]        imm_val,
    input  logic [IDX_W-1:0]     reg_idx,
    input  logic [NREGS*DW-1:0]  reg_bank,
    input  logic [DW-1:0]        acc_val,
    input  logic [AW-1:0]        jump_target,
    input  logic [AW-1:0]        fall_ip,
    output logic                 taken,
    output logic [AW-1:0]        ip_out
);
    logic [DW-1:0] operand_w;

    abu_operand_sel #(.DW(DW), .NREGS(NREGS), .IDX_W(IDX_W)) sel_i (
        .use_imm (use_imm),
        .imm_val (imm_val),
        .reg_idx (reg_idx),
        .reg_bank(reg_bank),
        .operand (operand_w)
    );

    abu_cond_eval #(.DW(DW)) eval_i (
        .op_valid (op_valid),
        .cond_code(cond_code),
        .operand  (operand_w),
        .acc_val  (acc_val),
        .taken    (taken)
    );

    // redirect to the target on a taken branch, else continue in line
    always_comb begin
        ip_out = taken ? jump_target : fall_ip;
    end
endmodule

// File: rtl/abu_checker.sv
// Module: property checker for acc_branch_unit, attached through bind.
// Assumes a purely combinational design, so checks are immediate.
module abu_checker
    import abu_pkg::*;
#(
    parameter int DW    = 16,
    parameter int NREGS = 16,
    parameter int IDX_W = 8,
    parameter int AW    = 16
) (
    input logic              op_valid,
    input logic [COND_W-1:0] cond_code,
    input logic              use_imm,
    input logic [DW-1:0]     imm_val,
    input logic [IDX_W-1:0]  reg_idx,
    input logic [DW-1:0]     acc_val,
    input logic [AW-1:0]     jump_target,
    input logic [AW-1:0]     fall_ip,
    input logic [DW-1:0]     operand,
    input logic              taken,
    input logic [AW-1:0]     ip_out
);
    // evaluate every property whenever any input settles
    always_comb begin
        // R1
        idle_no_take_chk: assert (op_valid || !taken);
        // R2
        always_take_chk: assert (!(op_valid && cond_code == BR_ALWAYS) || taken);
        // R4
        eq_match_chk: assert (!(op_valid && cond_code == BR_EQ) || (taken == (operand == acc_val)));
        // R9
        reserved_never_chk: assert (cond_code != BR_NEVER || !taken);
        // R10
        imm_pass_chk: assert (!use_imm || operand == imm_val);
        // R11
        oob_zero_chk: assert (use_imm || int'(reg_idx) < NREGS || operand == '0);
        // R12
        taken_target_chk: assert (!taken || ip_out == jump_target);
        // R12
        fall_through_chk: assert (taken || ip_out == fall_ip);
    end
endmodule

bind acc_branch_unit abu_checker #(.DW(DW), .NREGS(NREGS), .IDX_W(IDX_W), .AW(AW)) chk_i (
    .op_valid   (op_valid),
    .cond_code  (cond_code),
    .use_imm    (use_imm),
    .imm_val    (imm_val),
    .reg_idx    (reg_idx),
    .acc_val    (acc_val),
    .jump_target(jump_target),
    .fall_ip    (fall_ip),
    .operand    (operand_w),
    .taken      (taken),
    .ip_out     (ip_out)
);

// File: tb/acc_branch_unit_tb.sv
// Bench: seeded random plus directed corner cases for acc_branch_unit.
// Expected results come from the bench's own model functions.
module acc_branch_unit_tb_top;
    localparam int PERIOD = 10;
    localparam int DW     = 16;
    localparam int NREGS  = 16;
    localparam int IDX_W  = 8;
    localparam int AW     = 16;
    localparam int NRAND  = 3000;

    logic                clk = 1'b0;
    logic                op_valid = 1'b0;
    logic [2:0]          cond_code = '0;
    logic                use_imm = 1'b0;
    logic [DW-1:0]       imm_val = '0;
    logic [IDX_W-1:0]    reg_idx = '0;
    logic [NREGS*DW-1:0] reg_bank = '0;
    logic [DW-1:0]       acc_val = '0;
    logic [AW-1:0]       jump_target = '0;
    logic [AW-1:0]       fall_ip = '0;
    logic                taken;
    logic [AW-1:0]       ip_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    acc_branch_unit #(.DW(DW), .NREGS(NREGS), .IDX_W(IDX_W), .AW(AW)) dut_i (
        .op_valid(op_valid), .cond_code(cond_code), .use_imm(use_imm),
        .imm_val(imm_val), .reg_idx(reg_idx), .reg_bank(reg_bank),
        .acc_val(acc_val), .jump_target(jump_target), .fall_ip(fall_ip),
        .taken(taken), .ip_out(ip_out)
    );

    always #(PERIOD/2) clk = ~clk;

    // model: operand source per R10 and R11
    function automatic logic [DW-1:0] model_operand();
        if (use_imm) return imm_val;
        if (int'(reg_idx) >= NREGS) return '0;
        return reg_bank[int'(reg_idx)*DW +: DW];
    endfunction

    // model: condition table per R2 to R9, operand on the left
    function automatic bit model_taken(logic [DW-1:0] op);
        int a, b;
        a = int'($signed(op));
        b = int'($signed(acc_val));
        if (!op_valid) return 1'b0;
        case (cond_code)
            3'd0: return 1'b1;
            3'd1: return a != b;
            3'd2: return a == b;
            3'd3: return a > b;
            3'd4: return a < b;
            3'd5: return a >= b;
            3'd6: return a <= b;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string cond_tag();
        if (!op_valid) return "R1";
        case (cond_code)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            3'd6: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check_now(string extra);
        bit exp_t;
        logic [AW-1:0] exp_ip;
        exp_t  = model_taken(model_operand());
        exp_ip = exp_t ? jump_target : fall_ip;
        checks++;
        if (taken !== exp_t) begin
            failures++;
            $display("FAIL %s %s taken actual=%0b expected=%0b", cond_tag(), extra, taken, exp_t);
        end
        checks++;
        if (ip_out !== exp_ip) begin
            failures++;
            $display("FAIL R12 %s ip_out actual=%h expected=%h", extra, ip_out, exp_ip);
        end
    endtask

    // drive on the falling edge, sample a quarter period later
    task automatic apply(bit v, logic [2:0] c, bit ui, logic [DW-1:0] iv,
                         logic [IDX_W-1:0] ri, logic [DW-1:0] acc, string extra);
        @(negedge clk);
        op_valid = v; cond_code = c; use_imm = ui; imm_val = iv;
        reg_idx = ri; acc_val = acc;
        jump_target = 16'(($urandom() | 1) & 16'hFFFF);
        fall_ip = ~jump_target;
        #(PERIOD/4);
        check_now(extra);
    endtask

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < NREGS; i++) reg_bank[i*DW +: DW] = 16'(16'h1000 + i * 16'h0111);

        // R1: idle state, all conditions, including a compare that would take
        for (int c = 0; c < 8; c++) apply(1'b0, 3'(c), 1'b1, 16'h0005, '0, 16'h0005, "idle");

        // R5 R6: signed extremes, operand 0x8000 vs acc 0x7FFF and the reverse
        apply(1'b1, 3'd3, 1'b1, 16'h8000, '0, 16'h7FFF, "signed min vs max");
        apply(1'b1, 3'd4, 1'b1, 16'h8000, '0, 16'h7FFF, "signed min vs max");
        apply(1'b1, 3'd3, 1'b1, 16'h7FFF, '0, 16'h8000, "signed max vs min");
        apply(1'b1, 3'd4, 1'b1, 16'hFFFF, '0, 16'h0000, "minus one vs zero");
        // R5 orientation: operand 5 vs acc 3 takes, operand 3 vs acc 5 falls through
        apply(1'b1, 3'd3, 1'b1, 16'd5, '0, 16'd3, "orientation");
        apply(1'b1, 3'd3, 1'b1, 16'd3, '0, 16'd5, "orientation");
        // R7 R8 R3 R4: exact equality
        for (int c = 1; c < 7; c++) apply(1'b1, 3'(c), 1'b1, 16'h8000, '0, 16'h8000, "equal");
        // R9: reserved code with a matching compare
        apply(1'b1, 3'd7, 1'b1, 16'h0001, '0, 16'h0001, "reserved");
        // R2: unconditional
        apply(1'b1, 3'd0, 1'b1, 16'h0001, '0, 16'h7777, "always");
        // R10: last implemented register equals acc
        apply(1'b1, 3'd2, 1'b0, 16'hDEAD, 8'(NREGS-1), 16'(16'h1000 + (NREGS-1) * 16'h0111), "R10 last reg");
        apply(1'b1, 3'd2, 1'b0, 16'hDEAD, 8'd0, 16'h1000, "R10 reg0");
        // R11: out-of-range indices read zero
        apply(1'b1, 3'd2, 1'b0, 16'h1234, 8'(NREGS), 16'h0000, "R11 idx NREGS");
        apply(1'b1, 3'd2, 1'b0, 16'h1234, 8'd255, 16'h0000, "R11 idx 255");
        apply(1'b1, 3'd1, 1'b0, 16'h0000, 8'd200, 16'h0000, "R11 idx 200");

        // R13: change inputs with no clock edge in between and resample
        @(negedge clk);
        op_valid = 1'b1; cond_code = 3'd2; use_imm = 1'b1; imm_val = 16'h0042; acc_val = 16'h0042;
        #1 check_now("R13 before");
        acc_val = 16'h0043;
        #1 check_now("R13 after");

        // seeded random mix, with equality forced on a quarter of cases
        for (int n = 0; n < NRAND; n++) begin
            logic [DW-1:0] a;
            logic [DW-1:0] iv;
            a  = 16'($urandom());
            iv = ($urandom() % 4 == 0) ? a : 16'($urandom());
            if ($urandom() % 8 == 0) reg_bank[($urandom() % NREGS)*DW +: DW] = 16'($urandom());
            apply(($urandom() % 8) != 0, 3'($urandom()), 1'($urandom()), iv,
                  8'($urandom() % 24), a, "random");
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // watchdog: a hung run counts as one failed check
    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule